// File: doc/BRIEF.md
# Half-Word Access Bridge for a 32-Bit Register Bank

This bridge lets a master whose transfers are at most 16 bits wide reach a bank of 32-bit registers. A 32-bit register is covered by two half-word transfers. The lower half (address bit 1 clear) goes first, then the upper half (address bit 1 set). The bridge makes each such pair behave as one indivisible access to the register bank.

On writes, the lower half-word is parked in a staging register inside the bridge, and nothing reaches the bank yet. When the upper half-word arrives, the bridge issues a single 32-bit write made of the new upper half and the parked lower half. On reads, a lower half-word read fetches the whole register. The bridge returns the low 16 bits and freezes the high 16 bits in a read-hold register. A later upper half-word read is answered from that register without touching the bank, so both halves come from the same moment.

Full 32-bit transfers pass through unchanged. Byte transfers, and the reserved size code, are refused with an error response.

The bridge handles one request at a time. A sequencer with six states runs it:

- **IDLE** accepts a request and takes one of these transitions:
  - *refuse* leads to FAULT.
  - *commit* leads to WRITE, for a word write or an upper-half write.
  - *fetch* leads to FETCH, for a word read or a lower-half read.
  - *local* leads to LOCAL, for a lower-half write or an upper-half read.
- **WRITE** drives the bank write and the response together, then goes *done* to IDLE.
- **FETCH** drives the bank read, then goes *deliver* to RETURN.
- **RETURN** gives the read response and, for a lower-half read, loads the read-hold register. It then goes *done* to IDLE.
- **LOCAL** gives the response with no bank access, then goes *done* to IDLE.
- **FAULT** gives the error response, then goes *done* to IDLE.

Top module: `halfword_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. The staging register and the read-hold register are both zero: an upper-half read returns 0, and an upper-half write of value H writes {H, 16'h0000}.
- R2: A lower-half write (`req_size`=1, `req_haddr[0]`=0) stores `req_wdata[15:0]` in the staging register. It causes no bank write, and it is acknowledged with `rsp_valid` one cycle after acceptance.
- R3: An upper-half write (`req_size`=1, `req_haddr[0]`=1) issues exactly one bank write of {`req_wdata[15:0]`, staging register} to word address `req_haddr[ADDR_W-2:1]`. `reg_wr_en` and `rsp_valid` are high together one cycle after acceptance.
- R4: A lower-half read drives `reg_rd_en` one cycle after acceptance. Two cycles after acceptance it responds with {16'h0000, word[15:0]}, where the word is the bank data from the cycle after `reg_rd_en`. It stores word[31:16] in the read-hold register.
- R5: An upper-half read responds one cycle after acceptance with {16'h0000, read-hold register} and never asserts `reg_rd_en`.
- R6: A word write (`req_size`=2) issues one bank write of the full `req_wdata` one cycle after acceptance and leaves the staging register unchanged.
- R7: A word read (`req_size`=2) reads the bank and returns the full 32-bit word two cycles after acceptance. It leaves the read-hold register unchanged.
- R8: A request with `req_size`=0 (byte) or 3 (reserved) gets `rsp_valid` and `rsp_err` high for exactly one cycle, one cycle after acceptance. It causes no bank access and changes neither the staging register nor the read-hold register.
- R9: `req_ready` is low from the cycle after acceptance until the response has been given. Each accepted request gets exactly one response cycle. `reg_wr_en` and `reg_rd_en` are never high together.
- R10: The read-hold register keeps the value captured by the last lower-half read even if the bank word changes before the upper-half read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_haddr | input | ADDR_W-1 | Byte address bits [ADDR_W-1:1]; bit 0 of this port selects the upper half |
| req_wdata | input | DATA_W | Write data; half-word writes use bits [15:0] |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Refused transfer width |
| rsp_rdata | output | DATA_W | Read data, half-words zero-extended |
| reg_wr_en | output | 1 | Bank write strobe |
| reg_rd_en | output | 1 | Bank read strobe; data expected the next cycle |
| reg_addr | output | ADDR_W-2 | Bank word address |
| reg_wdata | output | DATA_W | Bank write data |
| reg_rdata | input | DATA_W | Bank read data, one cycle after `reg_rd_en` |

## Verification
The bench checks that the reset value of the staging register really is zero. It does this with an upper-half write issued before any lower-half write, which would expose a design that merges stale or unknown bits. A word write and two refused writes are placed between a lower-half write and its upper half. A design that lets either kind of transfer disturb the staging register would commit the wrong low half.

For the read snapshot, the bank word is overwritten between the two read halves. A design that re-reads the bank on the upper half, or that refreshes the read-hold register on word reads, returns new data instead of the frozen half. The bench also counts bank strobes on every transfer, so a lower-half write that leaks to the bank, or an upper-half read that re-fetches, shows up as an extra access.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_WORD_WR,
        OP_WORD_RD,
        OP_LO_WR,
        OP_HI_WR,
        OP_LO_RD,
        OP_HI_RD
    } acc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FETCH,
        ST_RETURN,
        ST_LOCAL,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/hwb_classify.sv
module hwb_classify
    import hwb_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] size,
    input  logic       hi_sel,
    output acc_op_e    op
);

    acc_size_e size_e;

    always_comb begin
        size_e = acc_size_e'(size);
        op     = OP_BAD;
        unique case (size_e)
            SZ_HALF: begin
                if (is_write) op = hi_sel ? OP_HI_WR : OP_LO_WR;
                else          op = hi_sel ? OP_HI_RD : OP_LO_RD;
            end
            SZ_WORD: op = is_write ? OP_WORD_WR : OP_WORD_RD;
            SZ_BYTE: op = OP_BAD;
            SZ_RSVD: op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/hwb_seq.sv
module hwb_seq
    import hwb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  acc_op_e op_in,
    output acc_op_e op_q,
    output logic    req_ready,
    output logic    latch_req,
    output logic    take_stage,
    output logic    capture_hold,
    output logic    reg_wr_en,
    output logic    reg_rd_en,
    output logic    rsp_valid,
    output logic    rsp_err
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register (with the latched request kind)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_BAD;
        end else begin
            state_q <= state_d;
            if (accept) op_q <= op_in;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (op_in)
                        OP_BAD:     state_d = ST_FAULT;   // refuse
                        OP_WORD_WR: state_d = ST_WRITE;   // commit
                        OP_HI_WR:   state_d = ST_WRITE;   // commit
                        OP_WORD_RD: state_d = ST_FETCH;   // fetch
                        OP_LO_RD:   state_d = ST_FETCH;   // fetch
                        OP_LO_WR:   state_d = ST_LOCAL;   // local
                        OP_HI_RD:   state_d = ST_LOCAL;   // local
                        default:    state_d = ST_FAULT;
                    endcase
                end
            end
            ST_WRITE:  state_d = ST_IDLE;                 // done
            ST_FETCH:  state_d = ST_RETURN;               // deliver
            ST_RETURN: state_d = ST_IDLE;                 // done
            ST_LOCAL:  state_d = ST_IDLE;                 // done
            ST_FAULT:  state_d = ST_IDLE;                 // done
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        latch_req    = 1'b0;
        take_stage   = 1'b0;
        capture_hold = 1'b0;
        reg_wr_en    = 1'b0;
        reg_rd_en    = 1'b0;
        rsp_valid    = 1'b0;
        rsp_err      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready  = 1'b1;
                latch_req  = accept && (op_in != OP_BAD);
                take_stage = accept && (op_in == OP_LO_WR);
            end
            ST_WRITE: begin
                reg_wr_en = 1'b1;
                rsp_valid = 1'b1;
            end
            ST_FETCH: begin
                reg_rd_en = 1'b1;
            end
            ST_RETURN: begin
                rsp_valid    = 1'b1;
                capture_hold = (op_q == OP_LO_RD);
            end
            ST_LOCAL: begin
                rsp_valid = 1'b1;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hwb_lanes.sv
module hwb_lanes
    import hwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_req,
    input  logic              take_stage,
    input  logic              capture_hold,
    input  acc_op_e           op_q,
    input  logic [ADDR_W-3:0] word_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-3:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] stage_q;
    logic [HALF_W-1:0] hold_q;
    logic [DATA_W-1:0] wdat_q;
    logic [ADDR_W-3:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            hold_q  <= '0;
            wdat_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (latch_req) begin
                wdat_q <= req_wdata;
                addr_q <= word_addr;
            end
            if (take_stage)   stage_q <= req_wdata[HALF_W-1:0];
            if (capture_hold) hold_q  <= reg_rdata[DATA_W-1:HALF_W];
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = (op_q == OP_HI_WR) ? {wdat_q[HALF_W-1:0], stage_q} : wdat_q;

    always_comb begin
        unique case (op_q)
            OP_WORD_RD: rsp_rdata = reg_rdata;
            OP_LO_RD:   rsp_rdata = {{HALF_W{1'b0}}, reg_rdata[HALF_W-1:0]};
            OP_HI_RD:   rsp_rdata = {{HALF_W{1'b0}}, hold_q};
            default:    rsp_rdata = '0;
        endcase
    end

endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
    import hwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-2:0] req_haddr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-3:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    acc_op_e op_in;
    acc_op_e op_q;
    logic    latch_req;
    logic    take_stage;
    logic    capture_hold;

    hwb_classify u_classify (
        .is_write (req_write),
        .size     (req_size),
        .hi_sel   (req_haddr[0]),
        .op       (op_in)
    );

    hwb_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .op_in        (op_in),
        .op_q         (op_q),
        .req_ready    (req_ready),
        .latch_req    (latch_req),
        .take_stage   (take_stage),
        .capture_hold (capture_hold),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_en    (reg_rd_en),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err)
    );

    hwb_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lanes (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_req    (latch_req),
        .take_stage   (take_stage),
        .capture_hold (capture_hold),
        .op_q         (op_q),
        .word_addr    (req_haddr[ADDR_W-2:1]),
        .req_wdata    (req_wdata),
        .reg_rdata    (reg_rdata),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .rsp_rdata    (rsp_rdata)
    );

endmodule

// File: rtl/halfword_bridge_chk.sv
module halfword_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [1:0] req_size,
    input logic       hi_sel,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       reg_wr_en,
    input logic       reg_rd_en
);

    logic acc;
    logic half;
    logic bad;

    assign acc  = req_valid && req_ready;
    assign half = (req_size == 2'd1);
    assign bad  = (req_size == 2'd0) || (req_size == 2'd3);

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en)); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R9

    AST_BAD_GIVES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bad |=> rsp_valid && rsp_err && !reg_wr_en && !reg_rd_en); // R8

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err); // R8

    AST_LOW_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && half && !hi_sel |=> rsp_valid && !reg_wr_en); // R2

    AST_HIGH_WRITE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && half && hi_sel |=> reg_wr_en && rsp_valid); // R3

    AST_LOW_READ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_write && half && !hi_sel |=> reg_rd_en && !rsp_valid); // R4

    AST_FETCH_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> rsp_valid && !rsp_err); // R4

    AST_HIGH_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_write && half && hi_sel |=> rsp_valid && !reg_rd_en && !rsp_err); // R5

    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && (req_size == 2'd2) |=> reg_wr_en); // R6

endmodule

bind halfword_bridge halfword_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .hi_sel    (req_haddr[0]),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/halfword_bridge_bench.sv
`timescale 1ns/1ps
module halfword_bridge_bench;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [ADDR_W-2:0] req_haddr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              reg_wr_en;
    logic              reg_rd_en;
    logic [ADDR_W-3:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata = '0;

    always #2.5 clk = ~clk;

    halfword_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_halfword_bridge (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_size (req_size), .req_haddr (req_haddr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
    );

    // register bank model: one-cycle read latency
    logic [31:0] mem [64];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr[5:0]] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd_en) begin
            reg_rdata <= mem[reg_addr[5:0]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic ready_after;
    logic rsp_after;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [1:0] sz, input logic [11:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_haddr = addr[11:1]; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ready_after = req_ready;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        rsp_after = rsp_valid;
    endtask

    logic [31:0] rd;
    logic        er;
    int          lat;
    int          w0, r0;

    task automatic t_reset();
        chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1", "no response after reset", {31'd0, rsp_valid}, 32'd0);
        do_req(1'b0, 2'd1, 12'h006, 32'h0, rd, er, lat);
        chk("R1", "reset hold value", rd, 32'h0);
        chk("R5", "upper read latency", lat, 32'd1);
        do_req(1'b1, 2'd1, 12'h00A, 32'h0000ABCD, rd, er, lat);
        chk("R1", "reset staging merged", mem[2], 32'hABCD0000);
    endtask

    task automatic t_word();
        w0 = wr_cnt; r0 = rd_cnt;
        do_req(1'b1, 2'd2, 12'h010, 32'hA5A51234, rd, er, lat);
        chk("R6", "word write data", mem[4], 32'hA5A51234);
        chk("R6", "word write count", wr_cnt - w0, 32'd1);
        chk("R9", "busy after accept", {31'd0, ready_after}, 32'd0);
        chk("R9", "single response cycle", {31'd0, rsp_after}, 32'd0);
        do_req(1'b0, 2'd2, 12'h010, 32'h0, rd, er, lat);
        chk("R7", "word read data", rd, 32'hA5A51234);
        chk("R7", "word read latency", lat, 32'd2);
        chk("R7", "word read count", rd_cnt - r0, 32'd1);
        do_req(1'b0, 2'd1, 12'h012, 32'h0, rd, er, lat);
        chk("R7", "hold untouched by word read", rd, 32'h0);
    endtask

    task automatic t_pair_write();
        w0 = wr_cnt;
        do_req(1'b1, 2'd1, 12'h020, 32'h7777BEEF, rd, er, lat);
        chk("R2", "lower write no bank access", wr_cnt - w0, 32'd0);
        chk("R2", "lower write latency", lat, 32'd1);
        chk("R2", "lower write no error", {31'd0, er}, 32'd0);
        do_req(1'b1, 2'd2, 12'h024, 32'h0F0F0F0F, rd, er, lat);
        w0 = wr_cnt;
        do_req(1'b1, 2'd1, 12'h022, 32'h0000CAFE, rd, er, lat);
        chk("R3", "upper write merged", mem[8], 32'hCAFEBEEF);
        chk("R3", "upper write count", wr_cnt - w0, 32'd1);
        chk("R6", "word write left other word", mem[9], 32'h0F0F0F0F);
    endtask

    task automatic t_pair_read();
        do_req(1'b1, 2'd2, 12'h030, 32'h11223344, rd, er, lat);
        r0 = rd_cnt;
        do_req(1'b0, 2'd1, 12'h030, 32'h0, rd, er, lat);
        chk("R4", "lower read data", rd, 32'h00003344);
        chk("R4", "lower read latency", lat, 32'd2);
        chk("R4", "lower read count", rd_cnt - r0, 32'd1);
        r0 = rd_cnt;
        do_req(1'b0, 2'd1, 12'h032, 32'h0, rd, er, lat);
        chk("R5", "upper read data", rd, 32'h00001122);
        chk("R5", "upper read no bank access", rd_cnt - r0, 32'd0);
    endtask

    task automatic t_snapshot();
        do_req(1'b1, 2'd2, 12'h030, 32'hDEAD0000, rd, er, lat);
        do_req(1'b0, 2'd1, 12'h032, 32'h0, rd, er, lat);
        chk("R10", "frozen upper half", rd, 32'h00001122);
        do_req(1'b0, 2'd1, 12'h030, 32'h0, rd, er, lat);
        chk("R10", "new lower half", rd, 32'h00000000);
        do_req(1'b0, 2'd1, 12'h032, 32'h0, rd, er, lat);
        chk("R10", "new upper half", rd, 32'h0000DEAD);
    endtask

    task automatic t_bad();
        w0 = wr_cnt; r0 = rd_cnt;
        do_req(1'b1, 2'd0, 12'h030, 32'hFFFFFFFF, rd, er, lat);
        chk("R8", "byte write error", {31'd0, er}, 32'd1);
        chk("R8", "error latency", lat, 32'd1);
        chk("R8", "error one cycle", {31'd0, rsp_after}, 32'd0);
        chk("R8", "byte write no bank write", wr_cnt - w0, 32'd0);
        do_req(1'b0, 2'd3, 12'h032, 32'h0, rd, er, lat);
        chk("R8", "reserved size error", {31'd0, er}, 32'd1);
        chk("R8", "reserved size no bank read", rd_cnt - r0, 32'd0);
        do_req(1'b1, 2'd0, 12'h040, 32'h00001111, rd, er, lat);
        do_req(1'b0, 2'd1, 12'h032, 32'h0, rd, er, lat);
        chk("R8", "hold kept across errors", rd, 32'h0000DEAD);
        do_req(1'b0, 2'd2, 12'h030, 32'h0, rd, er, lat);
        chk("R8", "bank word kept", rd, 32'hDEAD0000);
        do_req(1'b1, 2'd1, 12'h042, 32'h00005555, rd, er, lat);
        chk("R8", "staging kept across errors", mem[16], 32'h5555BEEF);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_pair_write();
        t_pair_read();
        t_snapshot();
        t_bad();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule